// File: doc/BRIEF.md
# Bulk-IN Endpoint Transmit Controller

This block is the transmit half of a single bulk-IN endpoint in a USB device controller. A processor or DMA engine pushes payload bytes into a small transmit FIFO through a simple register write/read port. When the host side signals an IN request, the block answers with either a NAK or one data packet. The packet is streamed byte by byte to a simplified serial-engine interface with a valid/ready handshake. Packet length is limited by a programmable maximum-packet register, which holds the size minus one.

After each packet a sticky completion flag is raised, and the endpoint interrupt follows it when enabled. While that flag is set, the endpoint is disarmed. If the FIFO runs dry partway through a packet, the packet is aborted and underrun plus packet-error flags are raised. Software then reloads the data and clears the flags to have the packet sent again. A control bit selects between two sizing policies. In automatic-short mode a short packet is sent whenever fewer bytes than the maximum are queued. In fixed mode every packet is maximum-sized, and software lowers the maximum for a final short packet.

Top module: `bulkin_tx_ep`

## Requirements
- R1: The max-packet register (address 2, low 4 bits) resets to 15 and holds packet size minus one. In fixed mode each packet carries exactly that value plus one bytes, and `tx_last` is high on the final byte only.
- R2: A packet or a NAK is produced only in response to `in_tok`. A single request yields at most one packet, and `resp_nak` is never high together with `tx_valid`.
- R3: With the auto-short control bit set (control register, address 3, bit 1), a request that finds fewer queued bytes than the maximum sends exactly the queued bytes as a short packet.
- R4: A request that finds the FIFO empty gets `resp_nak` in the same cycle, and no packet is started.
- R5: The completion flag (status register, address 1, bit 0) sets in the cycle after the last byte is accepted. While it is set, new requests are NAKed and the FIFO is untouched. Writing 1 to the bit clears it and re-arms the endpoint.
- R6: `ep_irq` equals the completion flag ANDed with the interrupt enable (control register bit 0).
- R7: The FIFO-service flag (status bit 1) reads 1 when the FIFO holds 8 bytes or fewer, and 0 otherwise.
- R8: If the FIFO is empty while a packet is in progress, `tx_err` pulses. The packet ends, and the underrun (status bit 2), packet-error (status bit 3) and completion flags are all set.
- R9: Underrun and packet-error are sticky and cleared by writing 1 to their bits. While either is set, requests are NAKed.
- R10: A data write (address 0) to a FIFO holding 16 bytes is dropped and sets the sticky overflow flag (status bit 4). Writing 1 to that bit clears the flag.
- R11: Bytes leave in the order they were written, and a read of address 0 returns the current FIFO fill level.
- R12: After reset, status reads 0x02, control reads 0x00, the fill level reads 0, and `ep_irq`, `tx_valid` and `resp_nak` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 max packet, 3 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| in_tok | input | 1 | IN request from the host-side engine, one-cycle pulse |
| resp_nak | output | 1 | NAK answer to the current `in_tok` |
| tx_valid | output | 1 | Payload byte available |
| tx_ready | input | 1 | Engine accepts the byte |
| tx_data | output | 8 | Payload byte |
| tx_last | output | 1 | Current byte is the last of the packet |
| tx_err | output | 1 | Underrun abort of the current packet |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
The bench uses the default parameters: a 16-byte FIFO, a 4-bit max-packet field and a service threshold of 8. Because the maximum packet equals the FIFO depth, one full-sized packet drains a full FIFO exactly. A 17th write reaches the overflow case within a few cycles. A fill of 8 against 9 bytes lands on the service threshold from both sides. Fixed mode with a maximum larger than the queued bytes is what brings the underrun path within reach, since auto-short mode never starts a packet it cannot finish.

// File: rtl/bulkin_pkg.sv
package bulkin_pkg;
   typedef enum logic [1:0] {
      RA_DATA = 2'd0,
      RA_STAT = 2'd1,
      RA_MAXP = 2'd2,
      RA_CTRL = 2'd3
   } reg_addr_e;

   // status register bit positions
   localparam int ST_DONE = 0;
   localparam int ST_SVC  = 1;
   localparam int ST_URUN = 2;
   localparam int ST_PERR = 3;
   localparam int ST_OVF  = 4;

   // control register bit positions
   localparam int CT_IRQEN = 0;
   localparam int CT_SHORT = 1;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;
endpackage

// File: rtl/bulkin_fifo.sv
module bulkin_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp <= wp + AW'(1);
         if (pop_ok)  rp <= rp + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/bulkin_regs.sv
module bulkin_regs
   import bulkin_pkg::*;
#(
   parameter int DW        = 8,
   parameter int MPS_W     = 4,
   parameter int CNT_W     = 5,
   parameter int SVC_LEVEL = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    wdata,
   input  logic [CNT_W-1:0] count,
   input  logic             fifo_full,
   input  logic             set_done,
   input  logic             set_urun,
   output logic [DW-1:0]    rdata,
   output logic             push,
   output logic             done,
   output logic             urun,
   output logic             perr,
   output logic             ovf,
   output logic             auto_short,
   output logic [MPS_W-1:0] mps,
   output logic             irq
);
   reg_addr_e ra;
   logic      irq_en, svc, wr_stat, wr_data;

   assign ra      = reg_addr_e'(addr);
   assign wr_stat = wr && (ra == RA_STAT);
   assign wr_data = wr && (ra == RA_DATA);
   assign push    = wr_data && !fifo_full;
   assign svc     = (int'(count) <= SVC_LEVEL);
   assign irq     = done && irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         urun       <= 1'b0;
         perr       <= 1'b0;
         ovf        <= 1'b0;
         irq_en     <= 1'b0;
         auto_short <= 1'b0;
         mps        <= '1;
      end else begin
         // a set event wins over a same-cycle clear
         done <= set_done || set_urun || (done && !(wr_stat && wdata[ST_DONE]));
         urun <= set_urun || (urun && !(wr_stat && wdata[ST_URUN]));
         perr <= set_urun || (perr && !(wr_stat && wdata[ST_PERR]));
         ovf  <= (wr_data && fifo_full) || (ovf && !(wr_stat && wdata[ST_OVF]));
         if (wr && ra == RA_MAXP) mps <= wdata[MPS_W-1:0];
         if (wr && ra == RA_CTRL) begin
            irq_en     <= wdata[CT_IRQEN];
            auto_short <= wdata[CT_SHORT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (ra)
         RA_DATA: rdata[CNT_W-1:0] = count;
         RA_STAT: begin
            rdata[ST_DONE] = done;
            rdata[ST_SVC]  = svc;
            rdata[ST_URUN] = urun;
            rdata[ST_PERR] = perr;
            rdata[ST_OVF]  = ovf;
         end
         RA_MAXP: rdata[MPS_W-1:0] = mps;
         RA_CTRL: begin
            rdata[CT_IRQEN] = irq_en;
            rdata[CT_SHORT] = auto_short;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/bulkin_txfsm.sv
module bulkin_txfsm
   import bulkin_pkg::*;
#(
   parameter int DW    = 8,
   parameter int MPS_W = 4,
   parameter int CNT_W = 5,
   localparam int LEN_W = MPS_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_tok,
   input  logic [CNT_W-1:0] count,
   input  logic             fifo_empty,
   input  logic [DW-1:0]    fifo_dout,
   input  logic [MPS_W-1:0] mps,
   input  logic             auto_short,
   input  logic             blocked,
   input  logic             tx_ready,
   output logic             pop,
   output logic             tx_valid,
   output logic [DW-1:0]    tx_data,
   output logic             tx_last,
   output logic             tx_err,
   output logic             resp_nak,
   output logic             set_done,
   output logic             set_urun
);
   tx_state_e  state;
   logic [LEN_W-1:0] remain, full_len, len_sel;
   logic             start, is_idle, is_send, fits_short;

   assign is_idle    = (state == TX_IDLE);
   assign is_send    = (state == TX_SEND);
   assign full_len   = {1'b0, mps} + LEN_W'(1);
   assign fits_short = auto_short && (int'(count) < int'(full_len));
   assign len_sel    = fits_short ? LEN_W'(count) : full_len;

   assign start    = is_idle && in_tok && !blocked && !fifo_empty;
   assign resp_nak = is_idle && in_tok && (blocked || fifo_empty);
   assign tx_valid = is_send && !fifo_empty;
   assign tx_data  = fifo_dout;
   assign tx_last  = tx_valid && (remain == LEN_W'(1));
   assign tx_err   = is_send && fifo_empty;
   assign pop      = tx_valid && tx_ready;
   assign set_done = pop && (remain == LEN_W'(1));
   assign set_urun = tx_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= TX_IDLE;
         remain <= '0;
      end else begin
         case (state)
            TX_IDLE: if (start) begin
               state  <= TX_SEND;
               remain <= len_sel;
            end
            TX_SEND: begin
               if (tx_err) begin
                  state <= TX_IDLE;
               end else if (pop) begin
                  remain <= remain - LEN_W'(1);
                  if (remain == LEN_W'(1)) state <= TX_IDLE;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bulkin_tx_ep.sv
module bulkin_tx_ep #(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int MPS_W      = 4,
   parameter int SVC_LEVEL  = 8,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              in_tok,
   output logic              resp_nak,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   output logic              tx_err,
   output logic              ep_irq
);
   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         initial $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 5 || DATA_W < CNT_W || DATA_W < MPS_W) begin : g_bad_width
         initial $error("DATA_W too narrow for status, level or max-packet fields");
      end
      if (SVC_LEVEL >= FIFO_DEPTH) begin : g_bad_svc
         initial $error("SVC_LEVEL must be below FIFO_DEPTH");
      end
   endgenerate

   logic [CNT_W-1:0]  fifo_cnt;
   logic              fifo_full, fifo_empty, push, pop;
   logic [DATA_W-1:0] fifo_dout;
   logic              done_q, urun_q, perr_q, ovf_q, auto_short;
   logic [MPS_W-1:0]  mps;
   logic              set_done, set_urun;

   bulkin_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(reg_wdata), .pop(pop),
      .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
   );

   bulkin_regs #(.DW(DATA_W), .MPS_W(MPS_W), .CNT_W(CNT_W), .SVC_LEVEL(SVC_LEVEL)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .count(fifo_cnt), .fifo_full(fifo_full), .set_done(set_done), .set_urun(set_urun),
      .rdata(reg_rdata), .push(push), .done(done_q), .urun(urun_q), .perr(perr_q),
      .ovf(ovf_q), .auto_short(auto_short), .mps(mps), .irq(ep_irq)
   );

   bulkin_txfsm #(.DW(DATA_W), .MPS_W(MPS_W), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .in_tok(in_tok), .count(fifo_cnt),
      .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .mps(mps),
      .auto_short(auto_short), .blocked(done_q || urun_q || perr_q),
      .tx_ready(tx_ready), .pop(pop), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_err(tx_err), .resp_nak(resp_nak),
      .set_done(set_done), .set_urun(set_urun)
   );
endmodule

// File: rtl/bulkin_tx_ep_chk.sv
module bulkin_tx_ep_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             tx_last,
   input logic             tx_err,
   input logic             resp_nak,
   input logic             ep_irq,
   input logic             pkt_done,
   input logic             urun,
   input logic             perr,
   input logic             ovf,
   input logic             fifo_full,
   input logic [CNT_W-1:0] fifo_cnt
);
   // R2
   nak_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_nak |-> !tx_valid);

   // R5
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> pkt_done);

   // R8
   urun_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_err |=> (urun && perr && pkt_done));

   // R10
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && fifo_full) |=> ovf);

   // R6
   irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ep_irq |-> pkt_done);

   // R11
   valid_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (fifo_cnt != '0));

   // R9
   blocked_no_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (urun || perr) |-> !tx_valid);
endmodule

bind bulkin_tx_ep bulkin_tx_ep_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last), .tx_err(tx_err),
   .resp_nak(resp_nak), .ep_irq(ep_irq), .pkt_done(done_q), .urun(urun_q),
   .perr(perr_q), .ovf(ovf_q), .fifo_full(fifo_full), .fifo_cnt(fifo_cnt)
);

// File: tb/bulkin_tx_ep_test.sv
module bulkin_tx_ep_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       in_tok = 1'b0;
   logic       resp_nak, tx_valid, tx_last, tx_err, ep_irq;
   logic       tx_ready = 1'b1;
   logic [7:0] tx_data;

   int n_chk = 0, n_fail = 0;
   int wcnt = 0, rcnt = 0;
   logic [7:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   bulkin_tx_ep uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_tok(in_tok),
      .resp_nak(resp_nak), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_last(tx_last), .tx_err(tx_err), .ep_irq(ep_irq)
   );

   // kind: 0 data packet, 1 NAK, 2 underrun
   // {bytes pushed, max packet minus one, auto-short, kind, expected length}
   localparam int NVEC = 7;
   localparam int VEC [NVEC][5] = '{
      '{ 4,  7, 1, 0,  4},   // R3 short packet
      '{12,  7, 1, 0,  8},   // R3 capped at max
      '{ 0,  7, 1, 0,  4},   // R3 leftover bytes
      '{ 0,  7, 1, 1,  0},   // R4 empty FIFO
      '{16, 15, 0, 0, 16},   // R1 full packet
      '{ 3,  2, 0, 0,  3},   // R1 reduced max
      '{ 2,  4, 0, 2,  2}    // R8 underrun
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic push_bytes(input int n);
      for (int i = 0; i < n; i++) begin
         wr_reg(2'd0, 8'(wcnt));
         if (wcnt - rcnt < DEPTH) wcnt++;
      end
   endtask

   task automatic in_request(input int kind, input int len, input string tag);
      int got = 0;
      bit last_ok = 1'b0, err_seen = 1'b0;
      in_tok = 1'b1;
      #1;
      chk(resp_nak == (kind == 1), {tag, " R2 nak answer"}, int'(resp_nak), int'(kind == 1));
      @(negedge clk);
      in_tok = 1'b0;
      if (kind != 1) begin
         for (int c = 0; c < len + 4; c++) begin
            #1;
            if (tx_err) begin err_seen = 1'b1; break; end
            if (tx_valid) begin
               chk(tx_data == 8'(rcnt), {tag, " R11 byte order"}, int'(tx_data), rcnt & 255);
               rcnt++; got++;
               if (tx_last) begin last_ok = (got == len); break; end
            end
            @(negedge clk);
         end
         @(negedge clk);
         chk(got == len, {tag, " R1 R3 packet length"}, got, len);
         if (kind == 0) chk(last_ok, {tag, " R1 tx_last position"}, int'(last_ok), 1);
         chk(err_seen == (kind == 2), {tag, " R8 tx_err"}, int'(err_seen), int'(kind == 2));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      rd_reg(2'd1, rv); chk(rv == 8'h02, "R12 status after reset", rv, 8'h02);
      rd_reg(2'd2, rv); chk(rv == 8'h0F, "R1 R12 max packet reset", rv, 8'h0F);
      rd_reg(2'd3, rv); chk(rv == 8'h00, "R12 control reset", rv, 0);
      rd_reg(2'd0, rv); chk(rv == 8'h00, "R12 fill level reset", rv, 0);
      chk(!ep_irq && !tx_valid && !resp_nak, "R12 outputs idle", {ep_irq, tx_valid, resp_nak}, 0);

      for (int v = 0; v < NVEC; v++) begin
         wr_reg(2'd2, 8'(VEC[v][1]));
         wr_reg(2'd3, {6'd0, 1'(VEC[v][2]), 1'b1});
         push_bytes(VEC[v][0]);
         in_request(VEC[v][3], VEC[v][4], $sformatf("vec%0d", v));
         rd_reg(2'd1, rv);
         if (VEC[v][3] == 0) begin
            chk((rv & 8'h1D) == 8'h01, "R5 done after packet", rv & 8'h1D, 8'h01);
            chk(ep_irq, "R6 irq with enable", int'(ep_irq), 1);
            wr_reg(2'd1, 8'h01);
            #1;
            chk(!ep_irq, "R5 R6 clear done drops irq", int'(ep_irq), 0);
         end else if (VEC[v][3] == 1) begin
            chk((rv & 8'h01) == 8'h00, "R4 no done on NAK", rv & 8'h01, 0);
         end else begin
            chk((rv & 8'h1D) == 8'h0D, "R8 underrun flags", rv & 8'h1D, 8'h0D);
            push_bytes(1);
            wr_reg(2'd1, 8'h01);            // clear done only
            in_request(1, 0, "R9 nak while underrun");
            wr_reg(2'd1, 8'h0C);
            rd_reg(2'd1, rv);
            chk((rv & 8'h0D) == 8'h00, "R9 write-one clears", rv & 8'h0D, 0);
         end
      end

      // R7 service threshold, level 1 left from the underrun step
      push_bytes(7);
      rd_reg(2'd1, rv); chk(rv[1] == 1'b1, "R7 svc at 8", int'(rv[1]), 1);
      push_bytes(1);
      rd_reg(2'd1, rv); chk(rv[1] == 1'b0, "R7 svc at 9", int'(rv[1]), 0);
      rd_reg(2'd0, rv); chk(rv == 8'd9, "R11 fill level", rv, 9);
      wr_reg(2'd2, 8'h0F);
      wr_reg(2'd3, 8'h03);
      in_request(0, 9, "R3 nine bytes");
      wr_reg(2'd1, 8'h01);

      // R10 overflow
      push_bytes(DEPTH + 1);
      rd_reg(2'd1, rv); chk(rv[4] == 1'b1, "R10 overflow flag", int'(rv[4]), 1);
      rd_reg(2'd0, rv); chk(rv == 8'(DEPTH), "R10 level capped", rv, DEPTH);
      wr_reg(2'd1, 8'h10);
      rd_reg(2'd1, rv); chk(rv[4] == 1'b0, "R10 overflow cleared", int'(rv[4]), 0);
      wr_reg(2'd3, 8'h01);
      in_request(0, 16, "R10 drain full FIFO");
      wr_reg(2'd1, 8'h01);

      // R6 masked interrupt, R5 disarm while done set
      wr_reg(2'd3, 8'h02);
      push_bytes(2);
      in_request(0, 2, "R6 masked packet");
      rd_reg(2'd1, rv); chk(rv[0] == 1'b1, "R5 done set", int'(rv[0]), 1);
      chk(!ep_irq, "R6 irq masked", int'(ep_irq), 0);
      push_bytes(1);
      in_request(1, 0, "R5 nak while done");
      rd_reg(2'd0, rv); chk(rv == 8'd1, "R5 FIFO untouched", rv, 1);
      wr_reg(2'd1, 8'h01);
      in_request(0, 1, "R5 re-armed");

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule